// File: doc/BRIEF.md
# Gated 16-bit Timer with Prescaler

This block is a 16-bit up-counter that software reaches through a small byte-wide register port. The count is held as a low byte and a high byte, and each byte can be read and written on its own. A control byte turns the timer on, picks the count source and the prescale ratio, and enables gating. The count source is either the system clock, which gives one tick per cycle, or the rising edges of an external pin after they pass a synchronizer. The prescaler divides that source by 1, 2, 4 or 8 before it reaches the counter.

With gating enabled, an active-low gate pin stops the count while it is high. This lets the timer measure how long an external signal stays low. When the count wraps from FFFFh to 0000h, an overflow flag is set. The flag stays set until software clears it with a strobe. The prescale counter cannot be read by software, and it is reset whenever either count byte is written. This lets software start a measurement from a known phase.

Top module: `gated_timer16`

## Requirements
- R1: After reset, the count is 0000h, the control byte reads 00h and the overflow flag is 0.
- R2: Address 0 holds the count low byte and address 1 holds the count high byte. Writing one byte leaves the other byte unchanged, and reads return the current count.
- R3: Address 2 is the control byte, with these bits: bit 0 = timer on, bit 1 = external source select, bit 3 = oscillator enable (stored and read back only), bits 5:4 = prescale select, bit 6 = gate enable. Bits 7 and 2 always read 0.
- R4: While the timer-on bit is 0, the count holds, whatever the gate enable and gate pin are doing.
- R5: Prescale select s gives a ratio of 2^s. After N source ticks that start from a cleared prescaler, the count has advanced by floor(N / 2^s). With the internal source, one tick is one clock cycle.
- R6: A write to either count byte clears the prescale counter. A write to the control byte leaves the prescale counter unchanged.
- R7: When the timer is on and gate enable is 1, the timer counts only while `gate_n` is low. When gate enable is 0, the timer counts whatever the level of `gate_n`.
- R8: When the external source is selected, each rising edge of `ext_clk` gives one source tick. A rising edge is counted on the third clock edge after it is sampled, because it passes a two-flop synchronizer and an edge detector. The pin must hold each level for at least two clock cycles.
- R9: A wrap from FFFFh to 0000h sets `ovf_flag` on the same clock edge. The flag stays set until `ovf_clr` is pulsed. If a clear and a wrap fall on the same edge, the flag ends up set.
- R10: A count-byte write on the same edge as an increment takes priority. The written byte is loaded and that increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 = count low, 1 = count high, 2 = control |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ext_clk | input | 1 | External count source, asynchronous |
| gate_n | input | 1 | Active-low gate, synchronous to `clk` |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps every prescale ratio against several run lengths, including lengths that stop one tick short of a ratio boundary. A prescaler that is off by one, or that decodes the ratio wrongly, therefore shows up as a count that differs by one. One sequence leaves the prescaler part-filled, restarts it through a control write, and then clears it through a count write. A design that cleared on the wrong kind of write, or on neither, would end one count high or low. Further checks aim at the wrap edge with a clear strobe on the same cycle, where a design that let the clear win would show no flag. They also aim at a count write that lands on an increment, where a design that let the increment win would read one higher than expected. External-edge runs are long enough that counting clock cycles instead of edges would give a very different result.

// File: rtl/gt16_pkg.sv
package gt16_pkg;
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int PS_BITS = 2;
  localparam int PS_CW   = (1 << PS_BITS) - 1;

  typedef struct packed {
    logic               gate_en;
    logic [PS_BITS-1:0] ps_sel;
    logic               osc_en;
    logic               ext_sel;
    logic               on;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.gate_en = b[6];
    c.ps_sel  = b[5:4];
    c.osc_en  = b[3];
    c.ext_sel = b[1];
    c.on      = b[0];
    return c;
  endfunction

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    return {1'b0, c.gate_en, c.ps_sel, c.osc_en, 1'b0, c.ext_sel, c.on};
  endfunction
endpackage

// File: rtl/gt16_sync_edge.sv
module gt16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_async,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], in_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gt16_prescaler.sv
module gt16_prescaler
  import gt16_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [PS_BITS-1:0] sel,
  output logic               tick
);
  logic [PS_CW-1:0] cnt_q;
  logic [PS_CW-1:0] cnt_d;
  logic [PS_CW-1:0] mask;

  for (genvar i = 0; i < PS_CW; i++) begin : g_mask
    assign mask[i] = (i < int'(sel));
  end

  assign tick = step & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gt16_counter.sv
module gt16_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inc,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             any_wr;

  assign any_wr = wr_lo | wr_hi;
  assign wrap   = inc & ~any_wr & (&cnt_q);
  assign count  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr) begin
      if (wr_lo) cnt_d[DATA_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:DATA_W] = wdata;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
  import gt16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic              gate_n,
  input  logic              ovf_clr,
  output logic              ovf_flag
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic             wr_lo, wr_hi, wr_ctrl, cnt_wr;
  logic             ext_rise, src_tick, run, step, ps_tick, wrap;
  logic [CNT_W-1:0] count;

  assign wr_lo   = bus_wr & (bus_addr == ADDR_LO);
  assign wr_hi   = bus_wr & (bus_addr == ADDR_HI);
  assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);
  assign cnt_wr  = wr_lo | wr_hi;

  gt16_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_async (ext_clk),
    .rise     (ext_rise)
  );

  assign run      = ctrl_q.on & (~ctrl_q.gate_en | ~gate_n);
  assign src_tick = ctrl_q.ext_sel ? ext_rise : 1'b1;
  assign step     = run & src_tick;

  gt16_prescaler u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_wr),
    .step  (step),
    .sel   (ctrl_q.ps_sel),
    .tick  (ps_tick)
  );

  gt16_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (bus_wdata),
    .inc   (ps_tick),
    .count (count),
    .wrap  (wrap)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = unpack_ctrl(bus_wdata[7:0]);
    flag_d = flag_q;
    if (wrap)         flag_d = 1'b1;
    else if (ovf_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;

  always_comb begin
    case (bus_addr)
      ADDR_LO:   bus_rdata = count[DATA_W-1:0];
      ADDR_HI:   bus_rdata = count[CNT_W-1:DATA_W];
      ADDR_CTRL: bus_rdata = DATA_W'(pack_ctrl(ctrl_q));
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gt16_checker.sv
module gt16_checker #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              gate_n,
  input logic              ovf_clr,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              cnt_wr,
  input logic              tmr_on,
  input logic              gate_en
);
  // R4
  a_r4_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_on && !cnt_wr) |=> $stable(cnt_q));
  // R7
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_on && gate_en && gate_n && !cnt_wr) |=> $stable(cnt_q));
  // R9
  a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_q) && !cnt_wr) |=> (cnt_q != '0 || ovf_flag));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R3
  a_r3_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[7] == 1'b0 && bus_rdata[2] == 1'b0));
  // R5
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

bind gated_timer16 gt16_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .gate_n    (gate_n),
  .ovf_clr   (ovf_clr),
  .ovf_flag  (ovf_flag),
  .cnt_q     (count),
  .cnt_wr    (cnt_wr),
  .tmr_on    (ctrl_q.on),
  .gate_en   (ctrl_q.gate_en)
);

// File: tb/test_gated_timer16.sv
module test_gated_timer16;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ext_clk;
  logic       gate_n;
  logic       ovf_clr;
  logic       ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;

  gated_timer16 i_gated_timer16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_clk   (ext_clk),
    .gate_n    (gate_n),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // enter and leave on a falling edge; the write lands on the rising edge between
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_count(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  // timer on for exactly n internal ticks: start write, n-1 idle cycles, stop write
  task automatic run_n(input logic [7:0] ctrl, input int n);
    wr(2'd2, ctrl | 8'h01);
    idle(n - 1);
    wr(2'd2, ctrl & 8'hFE);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    ext_clk = 1'b0; gate_n = 1'b1; ovf_clr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    read_count(v); chk("R1 count", 32'(v), 32'h0);
    rd(2'd2, b);   chk("R1 ctrl", 32'(b), 32'h0);
    chk("R1 flag", 32'(ovf_flag), 32'h0);

    // R2 byte access
    set_count(16'hA55A);
    read_count(v); chk("R2 both bytes", 32'(v), 32'hA55A);
    wr(2'd0, 8'h3C);
    read_count(v); chk("R2 low only", 32'(v), 32'hA53C);
    wr(2'd1, 8'h71);
    read_count(v); chk("R2 high only", 32'(v), 32'h713C);

    // R3 control layout
    wr(2'd2, 8'hFF);
    rd(2'd2, b); chk("R3 ctrl all ones", 32'(b), 32'h7B);
    wr(2'd2, 8'h38);
    rd(2'd2, b); chk("R3 ctrl osc+ps", 32'(b), 32'h38);
    wr(2'd2, 8'h00);

    // R4 timer off holds, gate low and gate enabled
    set_count(16'h0100);
    gate_n = 1'b0;
    wr(2'd2, 8'h40);
    idle(12);
    read_count(v); chk("R4 off holds", 32'(v), 32'h0100);
    wr(2'd2, 8'h00);
    gate_n = 1'b1;

    // R5 sweep of prescale ratios and run lengths
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        int n;
        logic [15:0] base;
        n = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 7 : (k == 3) ? 8 : 21;
        base = 16'h1200 + 16'(s * 16 + k);
        set_count(base);
        run_n(8'(s << 4), n);
        read_count(v);
        chk($sformatf("R5 ps=%0d n=%0d", s, n), 32'(v), 32'(base + 16'(n >> s)));
      end
    end

    // R6 control write keeps prescaler phase, count write clears it
    set_count(16'h0000);
    run_n(8'h30, 5);
    read_count(v); chk("R6 partial", 32'(v), 32'h0);
    run_n(8'h30, 3);
    read_count(v); chk("R6 ctrl keeps phase", 32'(v), 32'h1);
    run_n(8'h30, 5);
    wr(2'd0, 8'h00);
    run_n(8'h30, 7);
    read_count(v); chk("R6 count write clears", 32'(v), 32'h0);

    // R7 gate
    set_count(16'h0200);
    gate_n = 1'b1;
    run_n(8'h40, 10);
    read_count(v); chk("R7 gate high blocks", 32'(v), 32'h0200);
    gate_n = 1'b0;
    run_n(8'h40, 10);
    read_count(v); chk("R7 gate low counts", 32'(v), 32'h020A);
    gate_n = 1'b1;
    run_n(8'h00, 10);
    read_count(v); chk("R7 gate disabled counts", 32'(v), 32'h0214);

    // R8 external edges
    for (int s = 0; s < 3; s += 2) begin
      int ne;
      ne = (s == 0) ? 5 : 6;
      set_count(16'h0000);
      wr(2'd2, 8'(8'h03 | (s << 4)));
      for (int e = 0; e < ne; e++) begin
        ext_clk = 1'b1; idle(3);
        ext_clk = 1'b0; idle(3);
      end
      idle(6);
      wr(2'd2, 8'h02);
      read_count(v);
      chk($sformatf("R8 ext edges ps=%0d", s), 32'(v), 32'(ne >> s));
    end
    wr(2'd2, 8'h00);

    // R9 overflow flag
    set_count(16'hFFFE);
    run_n(8'h00, 1);
    chk("R9 no flag before wrap", 32'(ovf_flag), 32'h0);
    run_n(8'h00, 1);
    read_count(v); chk("R9 wrapped count", 32'(v), 32'h0);
    chk("R9 flag set", 32'(ovf_flag), 32'h1);
    idle(4);
    chk("R9 flag sticky", 32'(ovf_flag), 32'h1);
    ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
    chk("R9 flag cleared", 32'(ovf_flag), 32'h0);
    set_count(16'hFFFF);
    wr(2'd2, 8'h01);
    ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
    wr(2'd2, 8'h00);
    chk("R9 set wins over clear", 32'(ovf_flag), 32'h1);
    ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;

    // R10 write beats increment
    set_count(16'h0000);
    wr(2'd2, 8'h01);
    idle(3);
    wr(2'd0, 8'h50);
    wr(2'd2, 8'h00);
    read_count(v); chk("R10 write priority", 32'(v), 32'h0051);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule